// File: doc/BRIEF.md
# Lockable Two-Stage Watchdog Timer

This block is a down-counting watchdog timer with a simple APB register interface, all on one clock. Software programs a reload value and sets the run bit. The counter then steps down by one every clock. Each time it passes through zero it reloads itself. On the first such expiry it raises an interrupt. If that interrupt has not been serviced by the next expiry, and the reset-enable bit is set, the block drives a system reset request. Because of this two-stage escalation, software programs half of the intended reset interval.

Software services the timer by writing any value to the interrupt-clear register. This drops the pending interrupt and restarts the countdown from the reload value. A key register guards every other writable register. Writing the magic key opens them, and writing any other value closes them again. This keeps a runaway program from quietly disabling or reprogramming the watchdog.

Top module: `wdog_apb`

## Requirements
- R1: After reset, the reload register (0x000) and the live count (0x004) both read 0xFFFFFFFF, control (0x008) reads 0, the key register (0xC00) reads 0 (writes open), and both irqOut and sysRstOut are low.
- R2: A write to 0x000 sets the reload register and also loads the counter in the same clock. Offset 0x004 is read-only and returns the live count, so a write to it changes nothing.
- R3: While control bit 0 is set, the counter decrements once per clock. On a clock where it already holds zero, it reloads from the reload register and sets the pending interrupt. A reload value L therefore gives one expiry every L+1 clocks.
- R4: Control bit 0 is the run/interrupt enable and control bit 1 is the reset enable. Control bits 31:2 always read as zero.
- R5: sysRstOut is raised at an expiry only when the interrupt is already pending and control bit 1 is set. With bit 1 clear, any number of expiries leaves it low.
- R6: Any write to 0x00C clears the pending interrupt and reloads the counter from the reload register. A clear that lands on the same clock as an expiry wins, so no interrupt is set and no reset is raised.
- R7: Once sysRstOut is high, it stays high until rstN is asserted, whatever is written to the registers.
- R8: Writing 0x1ACCE551 to 0xC00 opens the registers, and writing any other value closes them. Writes to 0xC00 are always accepted. Reading 0xC00 returns 1 while closed and 0 while open.
- R9: While the registers are closed, writes to 0x000, 0x008 and 0x00C have no effect.
- R10: Bit 0 of 0x014 reads as the pending interrupt ANDed with control bit 0, and irqOut equals that bit.
- R11: Clearing control bit 0 freezes the counter at its present value and drops irqOut. A pending interrupt is kept and shows again once bit 0 is set.
- R12: A write takes effect on the clock where psel, penable and pwrite are all high. pready is always high, and reads of unmapped offsets (including 0x00C) return 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Single clock for bus and counter |
| rstN | input | 1 | Active-low asynchronous reset |
| psel | input | 1 | APB select |
| penable | input | 1 | APB access phase |
| pwrite | input | 1 | APB write (1) / read (0) |
| paddr | input | ADDR_W | APB byte address |
| pwdata | input | DATA_W | APB write data |
| prdata | output | DATA_W | APB read data |
| pready | output | 1 | Always ready |
| irqOut | output | 1 | Masked watchdog interrupt |
| sysRstOut | output | 1 | Sticky system reset request |

## Verification
The assertions assume a well-formed APB master: penable is only raised in the cycle after psel, and address and data hold steady across both phases. They also assume that each bus write names a single register, so the step and freeze properties can treat any cycle without a write as plain counting. The bench drives every access through one write task and one read task that build the two-phase sequence. It changes inputs only on falling edges and never overlaps two accesses, so the stimulus stays inside those assumptions.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

  localparam logic [11:0] OFS_RELOAD = 12'h000;
  localparam logic [11:0] OFS_COUNT  = 12'h004;
  localparam logic [11:0] OFS_CTRL   = 12'h008;
  localparam logic [11:0] OFS_CLEAR  = 12'h00C;
  localparam logic [11:0] OFS_STATUS = 12'h014;
  localparam logic [11:0] OFS_KEY    = 12'hC00;

  localparam int CTRL_RUN_BIT = 0;
  localparam int CTRL_RST_BIT = 1;
  localparam int CTRL_W       = 2;

  // strobes from the register/control side to the counting datapath
  typedef struct packed {
    logic reloadWr;  // new reload value, load counter at once
    logic clearWr;   // service write: drop interrupt, restart count
    logic runEn;     // counting enabled
    logic rstEn;     // escalation to system reset enabled
  } wdogStrobe_t;

endpackage

// File: rtl/wdog_dp.sv
module wdog_dp
  import wdog_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  wdogStrobe_t       strobe,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] reloadQ,
  output logic [DATA_W-1:0] countQ,
  output logic              pendQ,
  output logic              sysRstQ
);

  localparam logic [DATA_W-1:0] ALL_ONES = '1;
  localparam logic [DATA_W-1:0] ONE      = DATA_W'(1);

  logic              atZero;
  logic              expire;
  logic [DATA_W-1:0] countNext;

  assign atZero = (countQ == '0);
  // an expiry is lost to any same-cycle reload or service write
  assign expire = strobe.runEn && atZero && !strobe.reloadWr && !strobe.clearWr;

  always_comb begin
    countNext = countQ;
    if (strobe.reloadWr) begin
      countNext = wrData;
    end else if (strobe.clearWr) begin
      countNext = reloadQ;
    end else if (strobe.runEn) begin
      countNext = atZero ? reloadQ : (countQ - ONE);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      reloadQ <= ALL_ONES;
      countQ  <= ALL_ONES;
    end else begin
      if (strobe.reloadWr) reloadQ <= wrData;
      countQ <= countNext;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pendQ   <= 1'b0;
      sysRstQ <= 1'b0;
    end else begin
      if (strobe.clearWr) begin
        pendQ <= 1'b0;
      end else if (expire) begin
        pendQ <= 1'b1;
      end
      if (expire && pendQ && strobe.rstEn) sysRstQ <= 1'b1;
    end
  end

endmodule

// File: rtl/wdog_ctrl.sv
module wdog_ctrl
  import wdog_pkg::*;
#(
  parameter int              DATA_W     = 32,
  parameter int              ADDR_W     = 12,
  parameter logic [DATA_W-1:0] UNLOCK_KEY = 32'h1ACCE551
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [DATA_W-1:0] pwdata,
  input  logic [DATA_W-1:0] reloadVal,
  input  logic [DATA_W-1:0] countVal,
  input  logic              pendVal,
  output wdogStrobe_t       strobe,
  output logic [DATA_W-1:0] prdata,
  output logic [CTRL_W-1:0] ctrlQ,
  output logic              lockedQ,
  output logic              irqOut
);

  localparam logic [ADDR_W-1:0] A_RELOAD = ADDR_W'(OFS_RELOAD);
  localparam logic [ADDR_W-1:0] A_COUNT  = ADDR_W'(OFS_COUNT);
  localparam logic [ADDR_W-1:0] A_CTRL   = ADDR_W'(OFS_CTRL);
  localparam logic [ADDR_W-1:0] A_CLEAR  = ADDR_W'(OFS_CLEAR);
  localparam logic [ADDR_W-1:0] A_STATUS = ADDR_W'(OFS_STATUS);
  localparam logic [ADDR_W-1:0] A_KEY    = ADDR_W'(OFS_KEY);

  logic busWr;
  logic openWr;
  logic irqMasked;

  assign busWr  = psel && penable && pwrite;
  assign openWr = busWr && !lockedQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lockedQ <= 1'b0;
      ctrlQ   <= '0;
    end else begin
      if (busWr && (paddr == A_KEY)) lockedQ <= (pwdata != UNLOCK_KEY);
      if (openWr && (paddr == A_CTRL)) ctrlQ <= pwdata[CTRL_W-1:0];
    end
  end

  always_comb begin
    strobe          = '0;
    strobe.reloadWr = openWr && (paddr == A_RELOAD);
    strobe.clearWr  = openWr && (paddr == A_CLEAR);
    strobe.runEn    = ctrlQ[CTRL_RUN_BIT];
    strobe.rstEn    = ctrlQ[CTRL_RST_BIT];
  end

  assign irqMasked = pendVal && ctrlQ[CTRL_RUN_BIT];
  assign irqOut    = irqMasked;

  always_comb begin
    prdata = '0;
    if (psel && !pwrite) begin
      case (paddr)
        A_RELOAD: prdata = reloadVal;
        A_COUNT:  prdata = countVal;
        A_CTRL:   prdata = DATA_W'(ctrlQ);
        A_STATUS: prdata = DATA_W'(irqMasked);
        A_KEY:    prdata = DATA_W'(lockedQ);
        default:  prdata = '0;
      endcase
    end
  end

endmodule

// File: rtl/wdog_apb.sv
module wdog_apb
  import wdog_pkg::*;
#(
  parameter int                DATA_W     = 32,
  parameter int                ADDR_W     = 12,
  parameter logic [DATA_W-1:0] UNLOCK_KEY = 32'h1ACCE551
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [DATA_W-1:0] pwdata,
  output logic [DATA_W-1:0] prdata,
  output logic              pready,
  output logic              irqOut,
  output logic              sysRstOut
);

  wdogStrobe_t       strobe;
  logic [DATA_W-1:0] reloadQ;
  logic [DATA_W-1:0] countQ;
  logic              pendQ;
  logic [CTRL_W-1:0] ctrlQ;
  logic              lockedQ;

  wdog_ctrl #(
    .DATA_W    (DATA_W),
    .ADDR_W    (ADDR_W),
    .UNLOCK_KEY(UNLOCK_KEY)
  ) ctrl_i (
    .clk      (clk),
    .rstN     (rstN),
    .psel     (psel),
    .penable  (penable),
    .pwrite   (pwrite),
    .paddr    (paddr),
    .pwdata   (pwdata),
    .reloadVal(reloadQ),
    .countVal (countQ),
    .pendVal  (pendQ),
    .strobe   (strobe),
    .prdata   (prdata),
    .ctrlQ    (ctrlQ),
    .lockedQ  (lockedQ),
    .irqOut   (irqOut)
  );

  wdog_dp #(
    .DATA_W(DATA_W)
  ) dp_i (
    .clk    (clk),
    .rstN   (rstN),
    .strobe (strobe),
    .wrData (pwdata),
    .reloadQ(reloadQ),
    .countQ (countQ),
    .pendQ  (pendQ),
    .sysRstQ(sysRstOut)
  );

  assign pready = 1'b1;

endmodule

// File: rtl/wdog_apb_chk.sv
module wdog_apb_chk
  import wdog_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 12
) (
  input logic              clk,
  input logic              rstN,
  input logic              psel,
  input logic              penable,
  input logic              pwrite,
  input logic [ADDR_W-1:0] paddr,
  input logic [DATA_W-1:0] pwdata,
  input logic              irqOut,
  input logic              sysRstOut,
  input logic [DATA_W-1:0] reloadQ,
  input logic [DATA_W-1:0] countQ,
  input logic              pendQ,
  input logic [CTRL_W-1:0] ctrlQ,
  input logic              lockedQ
);

  logic busWr;
  assign busWr = psel && penable && pwrite;

  // R3: plain counting step
  assert_count_step_R3: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlQ[CTRL_RUN_BIT] && countQ != '0 && !busWr) |=> (countQ == $past(countQ) - DATA_W'(1)));

  // R3: expiry reloads and marks the interrupt pending
  assert_expiry_reload_R3: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlQ[CTRL_RUN_BIT] && countQ == '0 && !busWr) |=> (countQ == $past(reloadQ) && pendQ));

  // R5: reset only escalates from a pending interrupt with reset enabled
  assert_rst_escalation_R5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sysRstOut) |-> ($past(pendQ) && $past(ctrlQ[CTRL_RST_BIT])));

  // R6: an accepted service write drops the interrupt
  assert_clear_drops_irq_R6: assert property (@(posedge clk) disable iff (!rstN)
    (busWr && !lockedQ && paddr == ADDR_W'(OFS_CLEAR)) |=> !irqOut);

  // R7: reset request is sticky
  assert_rst_sticky_R7: assert property (@(posedge clk) disable iff (!rstN)
    sysRstOut |=> sysRstOut);

  // R9: closed registers keep the reload value
  assert_locked_reload_R9: assert property (@(posedge clk) disable iff (!rstN)
    (busWr && lockedQ && paddr == ADDR_W'(OFS_RELOAD)) |=> $stable(reloadQ));

  // R11: stopped counter holds its value
  assert_frozen_R11: assert property (@(posedge clk) disable iff (!rstN)
    (!ctrlQ[CTRL_RUN_BIT] && !busWr) |=> $stable(countQ));

  // R11: turning the run bit off hides the interrupt
  assert_stop_masks_irq_R11: assert property (@(posedge clk) disable iff (!rstN)
    (busWr && !lockedQ && paddr == ADDR_W'(OFS_CTRL) && !pwdata[CTRL_RUN_BIT]) |=> !irqOut);

endmodule

bind wdog_apb wdog_apb_chk #(
  .DATA_W(DATA_W),
  .ADDR_W(ADDR_W)
) chk_i (
  .clk      (clk),
  .rstN     (rstN),
  .psel     (psel),
  .penable  (penable),
  .pwrite   (pwrite),
  .paddr    (paddr),
  .pwdata   (pwdata),
  .irqOut   (irqOut),
  .sysRstOut(sysRstOut),
  .reloadQ  (reloadQ),
  .countQ   (countQ),
  .pendQ    (pendQ),
  .ctrlQ    (ctrlQ),
  .lockedQ  (lockedQ)
);

// File: tb/wdog_apb_tb_top.sv
`timescale 1ns/1ps
module wdog_apb_tb_top;

  localparam int DATA_W = 32;
  localparam int ADDR_W = 12;
  localparam logic [31:0] KEY = 32'h1ACCE551;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              psel = 1'b0;
  logic              penable = 1'b0;
  logic              pwrite = 1'b0;
  logic [ADDR_W-1:0] paddr = '0;
  logic [DATA_W-1:0] pwdata = '0;
  logic [DATA_W-1:0] prdata;
  logic              pready;
  logic              irqOut;
  logic              sysRstOut;

  int testsRun = 0;
  int testsFailed = 0;

  always #5 clk = ~clk;

  wdog_apb #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) dut_i (
    .clk(clk), .rstN(rstN), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .pready(pready),
    .irqOut(irqOut), .sysRstOut(sysRstOut)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    testsRun++;
    if (act !== exp) begin
      testsFailed++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
  endtask

  task automatic apbWrite(input logic [11:0] addr, input logic [31:0] data);
    @(negedge clk);
    psel = 1'b1; pwrite = 1'b1; penable = 1'b0; paddr = addr; pwdata = data;
    @(negedge clk);
    penable = 1'b1;
    @(negedge clk);
    psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
  endtask

  task automatic apbRead(input logic [11:0] addr, output logic [31:0] data);
    @(negedge clk);
    psel = 1'b1; pwrite = 1'b0; penable = 1'b0; paddr = addr;
    @(negedge clk);
    penable = 1'b1;
    data = prdata;
    psel = 1'b0; penable = 1'b0;
  endtask

  // negedges until sig is high, capped
  task automatic waitIrq(output int n);
    n = 0;
    while (!irqOut && n < 2000) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic waitSysRst(output int n);
    n = 0;
    while (!sysRstOut && n < 2000) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic testResetState();
    logic [31:0] d;
    doReset();
    apbRead(12'h000, d); check("R1 reload", d, 32'hFFFFFFFF);
    apbRead(12'h004, d); check("R1 count", d, 32'hFFFFFFFF);
    apbRead(12'h008, d); check("R1 ctrl", d, 32'h0);
    apbRead(12'hC00, d); check("R1 key", d, 32'h0);
    check("R1 irq", 32'(irqOut), 32'h0);
    check("R1 sysrst", 32'(sysRstOut), 32'h0);
    check("R12 pready", 32'(pready), 32'h1);
  endtask

  task automatic testReloadWrite();
    logic [31:0] d;
    doReset();
    apbWrite(12'h000, 32'd100);
    apbRead(12'h004, d); check("R2 count loaded", d, 32'd100);
    apbWrite(12'h004, 32'd5);
    apbRead(12'h004, d); check("R2 count read-only", d, 32'd100);
    apbRead(12'h000, d); check("R2 reload", d, 32'd100);
    apbRead(12'h010, d); check("R12 unmapped", d, 32'h0);
    apbRead(12'h00C, d); check("R12 clear reads 0", d, 32'h0);
  endtask

  task automatic testCtrlBits();
    logic [31:0] d;
    doReset();
    apbWrite(12'h008, 32'hFFFFFFFC);
    apbRead(12'h008, d); check("R4 reserved", d, 32'h0);
    apbWrite(12'h008, 32'hFFFFFFFF);
    apbRead(12'h008, d); check("R4 both bits", d, 32'h3);
  endtask

  task automatic testExpiryNoReset();
    logic [31:0] d;
    int n;
    doReset();
    apbWrite(12'h000, 32'd5);
    apbWrite(12'h008, 32'h1);
    waitIrq(n); check("R3 first expiry cycles", 32'(n), 32'd6);
    apbRead(12'h014, d); check("R10 status", d, 32'h1);
    repeat (30) @(negedge clk);
    check("R5 no reset without enable", 32'(sysRstOut), 32'h0);
    check("R10 irq held", 32'(irqOut), 32'h1);
  endtask

  task automatic testEscalation();
    int n;
    doReset();
    apbWrite(12'h000, 32'd4);
    apbWrite(12'h008, 32'h3);
    waitIrq(n); check("R3 expiry L=4", 32'(n), 32'd5);
    check("R5 no reset at first expiry", 32'(sysRstOut), 32'h0);
    waitSysRst(n); check("R5 second expiry cycles", 32'(n), 32'd5);
    apbWrite(12'h008, 32'h0);
    apbWrite(12'h00C, 32'h0);
    repeat (5) @(negedge clk);
    check("R7 sticky", 32'(sysRstOut), 32'h1);
    doReset();
    check("R7 cleared by reset", 32'(sysRstOut), 32'h0);
  endtask

  task automatic testServiceClear();
    logic [31:0] a;
    logic [31:0] b;
    int n;
    doReset();
    apbWrite(12'h000, 32'd4);
    apbWrite(12'h008, 32'h3);
    waitIrq(n);
    apbWrite(12'h00C, 32'h0);
    check("R6 irq cleared", 32'(irqOut), 32'h0);
    waitIrq(n); check("R6 reload after clear", 32'(n), 32'd5);
    check("R6 no reset after service", 32'(sysRstOut), 32'h0);
    // a fresh clear in a long period, then freeze and inspect the count
    apbWrite(12'h000, 32'd50);
    apbWrite(12'h00C, 32'h0);
    apbWrite(12'h008, 32'h0);
    apbRead(12'h004, a);
    check("R6 count restarted", 32'(a > 32'd40 && a < 32'd50), 32'h1);
    repeat (5) @(negedge clk);
    apbRead(12'h004, b); check("R11 frozen", b, a);
  endtask

  task automatic testLock();
    logic [31:0] d;
    int n;
    doReset();
    apbWrite(12'h000, 32'd3);
    apbWrite(12'h008, 32'h1);
    waitIrq(n);
    apbWrite(12'hC00, KEY ^ 32'h1);
    apbRead(12'hC00, d); check("R8 closed", d, 32'h1);
    apbWrite(12'h00C, 32'h0);
    check("R9 clear ignored", 32'(irqOut), 32'h1);
    apbWrite(12'h008, 32'h0);
    check("R9 ctrl ignored irq", 32'(irqOut), 32'h1);
    apbRead(12'h008, d); check("R9 ctrl ignored", d, 32'h1);
    apbWrite(12'h000, 32'h77);
    apbRead(12'h000, d); check("R9 reload ignored", d, 32'd3);
    apbWrite(12'hC00, KEY);
    apbRead(12'hC00, d); check("R8 opened", d, 32'h0);
    apbWrite(12'h000, 32'h77);
    apbRead(12'h000, d); check("R8 write after open", d, 32'h77);
  endtask

  task automatic testDisable();
    logic [31:0] a;
    logic [31:0] b;
    logic [31:0] d;
    int n;
    doReset();
    apbWrite(12'h000, 32'd3);
    apbWrite(12'h008, 32'h1);
    waitIrq(n);
    apbWrite(12'h008, 32'h0);
    check("R11 irq masked", 32'(irqOut), 32'h0);
    apbRead(12'h014, d); check("R10 status masked", d, 32'h0);
    apbRead(12'h004, a);
    repeat (7) @(negedge clk);
    apbRead(12'h004, b); check("R11 count held", b, a);
    apbWrite(12'h008, 32'h1);
    check("R11 pending kept", 32'(irqOut), 32'h1);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    testsFailed++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin : main
    testResetState();
    testReloadWrite();
    testCtrlBits();
    testExpiryNoReset();
    testEscalation();
    testServiceClear();
    testLock();
    testDisable();
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

endmodule